// File: doc/BRIEF.md
# Engine Halt Handshake Controller

This controller stops a communication engine cleanly when a halt is requested. A requester raises a level-sensitive halt request. The controller waits for a safe point to stop the engine's bit-time prescaler. A safe point needs two things: no transmit or receive activity in progress, and the module not in low-power mode. At that point it drops the prescaler enable and raises a read-only acknowledge. Software polls the acknowledge to learn that the engine is actually halted.

When the request is dropped, the controller turns the prescaler enable back on at once. It keeps the acknowledge high until the prescaler reports that it is counting again. A request that is withdrawn before the safe point arrives is dropped without any acknowledge. The busy and low-power indications come from elsewhere and are only observed here.

Top module: `halt_handshake`

## Requirements
- R1: After reset the acknowledge `haltAck` is 0 and the prescaler enable `prescEnable` is 1.
- R2: If `haltReq`=1, `engineBusy`=0 and `lowPower`=0 are sampled at a clock edge while `haltAck` is 0, then after that edge `haltAck` is 1 and `prescEnable` is 0.
- R3: While `engineBusy` is 1, a pending request is not granted. The grant happens at the first edge where the request is still held and `engineBusy` is 0.
- R4: While `lowPower` is 1, a pending request is not granted. The grant happens only at an edge where `lowPower` has returned to 0.
- R5: `prescEnable` is never 0 unless `haltAck` is 1.
- R6: When `haltReq` is sampled 0 while halted, `prescEnable` returns to 1 after that edge and `haltAck` stays 1. `haltAck` clears at the edge after `prescRunning` is sampled 1.
- R7: A request withdrawn before it is granted returns the controller to running without `haltAck` ever going to 1.
- R8: While halted and with the request held, changes on `engineBusy`, `lowPower` and `prescRunning` have no effect on either output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| haltReq | input | 1 | Halt request level |
| engineBusy | input | 1 | A frame is being transmitted or received |
| lowPower | input | 1 | Module is in low-power mode |
| prescRunning | input | 1 | Feedback: prescaler is counting |
| prescEnable | output | 1 | Run enable to the prescaler |
| haltAck | output | 1 | Halt acknowledge, read-only status |

## Verification
The assertions check on every cycle the following:
- the prescaler never stops without the acknowledge;
- a grant only follows a sampled idle, full-power request;
- the acknowledge never clears before the prescaler has been re-enabled;
- an unrequested controller never acknowledges.

Only the bench scenarios can show the following:
- the exact cycle on which a held-off grant lands after busy or low power drops;
- the two-step release order across several cycles of waiting for the feedback;
- a re-request arriving during release.

// File: rtl/halt_handshake_pkg.sv
package halt_handshake_pkg;

  typedef enum logic [1:0] {
    ST_RUN      = 2'd0,
    ST_WAIT     = 2'd1,
    ST_HALTED   = 2'd2,
    ST_RESUMING = 2'd3
  } haltState_t;

  typedef struct packed {
    logic setAck;
    logic clrAck;
    logic stopPresc;
    logic runPresc;
  } haltStrobe_t;

endpackage

// File: rtl/halt_handshake_ctrl.sv
module halt_handshake_ctrl
  import halt_handshake_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        haltReq,
  input  logic        engineBusy,
  input  logic        lowPower,
  input  logic        prescRunning,
  output haltStrobe_t strobe
);

  haltState_t state, stateNext;
  logic safePoint;

  assign safePoint = haltReq && !engineBusy && !lowPower;

  always_comb begin
    stateNext = state;
    strobe    = '0;
    unique case (state)
      ST_RUN, ST_WAIT: begin
        if (safePoint) begin
          stateNext        = ST_HALTED;
          strobe.setAck    = 1'b1;
          strobe.stopPresc = 1'b1;
        end else if (haltReq) begin
          stateNext = ST_WAIT;
        end else begin
          stateNext = ST_RUN;
        end
      end
      ST_HALTED: begin
        if (!haltReq) begin
          stateNext       = ST_RESUMING;
          strobe.runPresc = 1'b1;
        end
      end
      ST_RESUMING: begin
        if (prescRunning) begin
          stateNext     = ST_RUN;
          strobe.clrAck = 1'b1;
        end
      end
      default: stateNext = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_RUN;
    else       state <= stateNext;
  end

  assert_strobes_exclusive_R5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.setAck, strobe.clrAck, strobe.runPresc}));

  assert_release_needs_feedback_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clrAck |-> (state == ST_RESUMING) && prescRunning);

endmodule

// File: rtl/halt_handshake_dp.sv
module halt_handshake_dp
  import halt_handshake_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  haltStrobe_t strobe,
  output logic        prescEnable,
  output logic        haltAck
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      haltAck     <= 1'b0;
      prescEnable <= 1'b1;
    end else begin
      if (strobe.setAck)         haltAck <= 1'b1;
      else if (strobe.clrAck)    haltAck <= 1'b0;
      if (strobe.stopPresc)      prescEnable <= 1'b0;
      else if (strobe.runPresc)  prescEnable <= 1'b1;
    end
  end

  assert_stop_implies_ack_R5: assert property (@(posedge clk) disable iff (!rstN)
    !prescEnable |-> haltAck);

  assert_ack_clears_after_restart_R6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(haltAck) |-> $past(prescEnable));

endmodule

// File: rtl/halt_handshake.sv
module halt_handshake
  import halt_handshake_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic haltReq,
  input  logic engineBusy,
  input  logic lowPower,
  input  logic prescRunning,
  output logic prescEnable,
  output logic haltAck
);

  haltStrobe_t strobe;

  halt_handshake_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .haltReq      (haltReq),
    .engineBusy   (engineBusy),
    .lowPower     (lowPower),
    .prescRunning (prescRunning),
    .strobe       (strobe)
  );

  halt_handshake_dp u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .prescEnable (prescEnable),
    .haltAck     (haltAck)
  );

  assert_grant_when_safe_R2: assert property (@(posedge clk) disable iff (!rstN)
    (haltReq && !engineBusy && !lowPower && !haltAck) |=> (haltAck && !prescEnable));

  assert_grant_not_busy_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(haltAck) |-> $past(!engineBusy && haltReq));

  assert_grant_not_lowpower_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(haltAck) |-> $past(!lowPower));

  assert_ack_holds_R6: assert property (@(posedge clk) disable iff (!rstN)
    (haltAck && !prescRunning) |=> haltAck);

  assert_no_ack_unrequested_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!haltReq && !haltAck) |=> !haltAck);

  assert_halted_stable_R8: assert property (@(posedge clk) disable iff (!rstN)
    (haltReq && haltAck && !prescEnable) |=> (haltAck && !prescEnable));

endmodule

// File: tb/halt_handshake_tb.sv
module halt_handshake_tb;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic haltReq = 1'b0, engineBusy = 1'b0, lowPower = 1'b0, prescRunning = 1'b1;
  logic prescEnable, haltAck;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  typedef struct {
    logic  ack;
    logic  en;
    string tag;
  } expItem_t;

  expItem_t expQ[$];

  always #4 clk = ~clk;

  halt_handshake u_dut (
    .clk(clk), .rstN(rstN), .haltReq(haltReq), .engineBusy(engineBusy),
    .lowPower(lowPower), .prescRunning(prescRunning),
    .prescEnable(prescEnable), .haltAck(haltAck)
  );

  task automatic drive(input logic req, input logic busy, input logic lp,
                       input logic run, input logic eAck, input logic eEn,
                       input string tag);
    expItem_t it;
    @(negedge clk);
    haltReq = req; engineBusy = busy; lowPower = lp; prescRunning = run;
    it.ack = eAck; it.en = eEn; it.tag = tag;
    expQ.push_back(it);
  endtask

  always @(posedge clk) begin
    #1;
    if (rstN && expQ.size() > 0) begin
      expItem_t it;
      it = expQ.pop_front();
      vectors++;
      if (haltAck !== it.ack || prescEnable !== it.en) begin
        miscompares++;
        $display("FAIL %s: ack=%b en=%b expected ack=%b en=%b",
                 it.tag, haltAck, prescEnable, it.ack, it.en);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    vectors++;
    if (haltAck !== 1'b0 || prescEnable !== 1'b1) begin
      miscompares++;
      $display("FAIL R1 reset: ack=%b en=%b expected ack=0 en=1", haltAck, prescEnable);
    end
    rstN = 1'b1;
    //      req busy lp run  ack en
    drive(0, 0, 0, 1, 0, 1, "R7 idle no request");
    drive(1, 1, 0, 1, 0, 1, "R3 busy holds off");
    drive(1, 1, 0, 1, 0, 1, "R3 busy still holds off");
    drive(1, 0, 0, 1, 1, 0, "R3 grant when busy ends");
    drive(1, 1, 1, 0, 1, 0, "R8 halted ignores inputs");
    drive(0, 0, 0, 0, 1, 1, "R6 release reenables prescaler");
    drive(0, 0, 0, 0, 1, 1, "R6 ack held without feedback");
    drive(0, 0, 0, 1, 0, 1, "R6 ack clears after feedback");
    drive(0, 0, 0, 1, 0, 1, "R6 running");
    drive(1, 0, 1, 1, 0, 1, "R4 low power holds off");
    drive(1, 0, 1, 1, 0, 1, "R4 low power still holds off");
    drive(1, 0, 0, 1, 1, 0, "R4 grant after low power exit");
    drive(0, 0, 0, 1, 1, 1, "R6 release with feedback already high");
    drive(0, 0, 0, 1, 0, 1, "R6 clear");
    drive(1, 1, 0, 1, 0, 1, "R7 pending request");
    drive(0, 0, 0, 1, 0, 1, "R7 withdrawn, no ack");
    drive(0, 0, 0, 1, 0, 1, "R7 stays running");
    drive(1, 0, 0, 1, 1, 0, "R2 direct grant");
    drive(0, 0, 0, 1, 1, 1, "R6 resuming");
    drive(1, 0, 0, 1, 0, 1, "R6 rerequest during resume completes resume");
    drive(1, 0, 0, 1, 1, 0, "R2 regrant");
    drive(1, 1, 1, 0, 1, 0, "R8 halted ignores busy and low power");
    @(negedge clk);
    @(negedge clk);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #20000;
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: run did not complete");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule